// File: doc/BRIEF.md
# 2B1Q Transmit Symbol Source with Selectable Scrambler

This block supplies one line symbol per symbol period for a four-level (2B1Q) transmitter. Each symbol is a sign bit and a magnitude bit, together with a signed level code that the line driver can use directly. A one-cycle symbol strobe marks each symbol period. On a strobe the block reads its 3-bit mode selector and a polynomial-select bit. It then works out the next symbol and registers it, and the registered symbol holds until the next strobe.

There are two groups of working modes. The scrambled modes pass a constant logic one, or the channel-side sign/magnitude pair, through a 23-stage self-synchronizing scrambler. The polynomial-select bit picks one of two feedback polynomials for that scrambler. The two-level modes pin the magnitude bit to zero, so that only the outer levels reach the line. One of them sends the channel sign bit without scrambling. The other scrambles a constant one once per symbol. The remaining mode codes produce a quiet symbol and leave the scrambler untouched.

Top module: `tx2b1q_sym_src`

## Requirements
- R1: Reset is synchronous and active-low. Reset clears `sym_sign` and `sym_mag` to 0, so `sym_level` reads -3. Reset also loads every scrambler stage with 1. As a result, the first mode 3'b011 symbol with `poly_sel`=0 after reset is sign=1, magnitude=1 (level +1).
- R2: The outputs and the scrambler state change only in the clock cycle after a cycle where `sym_stb` is high. Between strobes, changes to the mode, polynomial or channel inputs have no effect on them.
- R3: Mode 3'b011 scrambles a constant 1 twice per symbol. The first scrambled bit becomes `sym_sign` and the second becomes `sym_mag`.
- R4: Mode 3'b101 scrambles `cu_sign` and then `cu_mag`, both sampled on the strobe. It outputs the two scrambled bits as sign and magnitude, in that order.
- R5: Mode 3'b110 outputs `cu_sign` unchanged as `sym_sign` and forces `sym_mag` to 0. The scrambler state is not advanced.
- R6: Mode 3'b111 scrambles a constant 1 exactly once per symbol to form `sym_sign`, and forces `sym_mag` to 0.
- R7: Modes 3'b000, 3'b001, 3'b010 and 3'b100 output sign=0 and magnitude=0, and they do not advance the scrambler.
- R8: Each scrambled bit is `b[n] = d[n] ^ b[n-k] ^ b[n-23]`, where b is the scrambler output stream. k is 5 when `poly_sel`=0 and 18 when `poly_sel`=1. `poly_sel` is sampled with each strobe.
- R9: `sym_level` is a 3-bit two's-complement value derived from the registered sign and magnitude. Sign=1 gives a positive level and sign=0 a negative one. Magnitude=0 gives 3 and magnitude=1 gives 1, so the four codes are +3, +1, -1 and -3.
- R10: The scrambling is self-synchronizing. A descrambler that starts from any state and applies `d[n] = b[n] ^ b[n-k] ^ b[n-23]` recovers the channel bits exactly once it has seen 23 scrambled bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sym_stb | input | 1 | One-cycle pulse that starts a symbol period |
| mode_sel | input | 3 | Transmit mode selector |
| poly_sel | input | 1 | Scrambler polynomial select (0: taps 5/23, 1: taps 18/23) |
| cu_sign | input | 1 | Sign bit from the channel-unit side |
| cu_mag | input | 1 | Magnitude bit from the channel-unit side |
| sym_sign | output | 1 | Registered transmit sign bit |
| sym_mag | output | 1 | Registered transmit magnitude bit |
| sym_level | output | 3 | Signed level code: +3, +1, -1 or -3 |

## Verification
The scrambler register feeds back into itself, so a single wrong stage or a wrong tap does not stay local. It alters the output stream no later than the first scrambled bit that reads that stage. In the worst case this is 23 bits, about twelve four-level symbols, after the fault, and the stream then keeps differing from the recurrence. A step taken in a quiet or unscrambled mode, or a step taken without a strobe, shifts the whole sequence. This shows at the sign/magnitude ports on the next scrambled symbol. A wrong level mapping or a leaked magnitude bit shows at the ports in the cycle right after the strobe.

// File: rtl/tx2b1q_pkg.sv
// Package: shared constants and types for the 2B1Q transmit symbol source.
// Assumes: mode codes are fixed by the transmit control field layout.
package tx2b1q_pkg;

    // Mode selector codes
    localparam logic [2:0] MD_IDLE0  = 3'b000;
    localparam logic [2:0] MD_IDLE1  = 3'b001;
    localparam logic [2:0] MD_IDLE2  = 3'b010;
    localparam logic [2:0] MD_ONES4  = 3'b011;
    localparam logic [2:0] MD_RSVD   = 3'b100;
    localparam logic [2:0] MD_DATA4  = 3'b101;
    localparam logic [2:0] MD_DATA2  = 3'b110;
    localparam logic [2:0] MD_ONES2  = 3'b111;

    // Decoded per-symbol control
    typedef struct packed {
        logic       idle;      // quiet symbol, no scrambler step
        logic       bypass;    // sign passed through unscrambled
        logic       two_lvl;   // magnitude forced to zero
        logic       use_data;  // scrambler input from channel side
        logic [1:0] steps;     // scrambler steps this symbol
    } sym_ctrl_t;

endpackage

// File: rtl/tx2b1q_mode_dec.sv
// Module: tx2b1q_mode_dec
// Turns the 3-bit mode selector into per-symbol control fields.
// Assumes: purely combinational; any unlisted code is treated as quiet.
module tx2b1q_mode_dec
    import tx2b1q_pkg::*;
(
    input  logic [2:0] mode_i,
    output sym_ctrl_t  ctrl_o
);

    // Mode table lookup
    always_comb begin
        ctrl_o = '{idle: 1'b1, bypass: 1'b0, two_lvl: 1'b0,
                   use_data: 1'b0, steps: 2'd0};
        case (mode_i)
            MD_ONES4: ctrl_o = '{idle: 1'b0, bypass: 1'b0, two_lvl: 1'b0,
                                 use_data: 1'b0, steps: 2'd2};
            MD_DATA4: ctrl_o = '{idle: 1'b0, bypass: 1'b0, two_lvl: 1'b0,
                                 use_data: 1'b1, steps: 2'd2};
            MD_DATA2: ctrl_o = '{idle: 1'b0, bypass: 1'b1, two_lvl: 1'b1,
                                 use_data: 1'b1, steps: 2'd0};
            MD_ONES2: ctrl_o = '{idle: 1'b0, bypass: 1'b0, two_lvl: 1'b1,
                                 use_data: 1'b0, steps: 2'd1};
            default:  ;
        endcase
    end

endmodule

// File: rtl/tx2b1q_scr_core.sv
// Module: tx2b1q_scr_core
// Self-synchronizing scrambler, b[n] = d[n] ^ b[n-k] ^ b[n-LEN], with k
// chosen from two taps. Unrolled to MAX_STEPS bits per clock; steps_i
// picks how many of them are committed when adv_i is high.
// Assumes: state bit 0 holds the newest scrambled bit; reset fills ones.
module tx2b1q_scr_core #(
    parameter int LEN       = 23,
    parameter int TAP_A     = 5,
    parameter int TAP_B     = 18,
    parameter int MAX_STEPS = 2,
    localparam int STW      = $clog2(MAX_STEPS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 adv_i,
    input  logic                 poly_sel_i,
    input  logic [STW-1:0]       steps_i,
    input  logic [MAX_STEPS-1:0] din_i,
    output logic [MAX_STEPS-1:0] dout_o,
    output logic [LEN-1:0]       state_o
);

    logic [LEN-1:0]                 state_q;
    logic [LEN-1:0]                 state_d;
    logic [MAX_STEPS:0][LEN-1:0]    chain;

    assign chain[0] = state_q;

    // Unrolled scrambler stages, one per bit of the symbol
    for (genvar k = 0; k < MAX_STEPS; k++) begin : g_step
        logic tap_bit;
        assign tap_bit    = poly_sel_i ? chain[k][TAP_B-1] : chain[k][TAP_A-1];
        assign dout_o[k]  = din_i[k] ^ tap_bit ^ chain[k][LEN-1];
        assign chain[k+1] = {chain[k][LEN-2:0], dout_o[k]};
    end

    // Pick the state after the requested number of steps
    always_comb begin
        state_d = chain[0];
        for (int k = 1; k <= MAX_STEPS; k++) begin
            if (int'(steps_i) == k) state_d = chain[k];
        end
    end

    // State register with all-ones reset
    always_ff @(posedge clk) begin
        if (!rst_n)     state_q <= '1;
        else if (adv_i) state_q <= state_d;
    end

    assign state_o = state_q;

endmodule

// File: rtl/tx2b1q_lvl_map.sv
// Module: tx2b1q_lvl_map
// Maps a sign/magnitude pair to a signed 2B1Q level code.
// Assumes: sign 1 is positive, magnitude 0 is the outer level (3).
module tx2b1q_lvl_map #(
    parameter int LVL_W = 3
) (
    input  logic                    sign_i,
    input  logic                    mag_i,
    output logic signed [LVL_W-1:0] level_o
);

    localparam logic signed [LVL_W-1:0] L_P3 = LVL_W'(3);
    localparam logic signed [LVL_W-1:0] L_P1 = LVL_W'(1);
    localparam logic signed [LVL_W-1:0] L_N1 = -LVL_W'(1);
    localparam logic signed [LVL_W-1:0] L_N3 = -LVL_W'(3);

    // Level lookup
    always_comb begin
        case ({sign_i, mag_i})
            2'b10:   level_o = L_P3;
            2'b11:   level_o = L_P1;
            2'b01:   level_o = L_N1;
            default: level_o = L_N3;
        endcase
    end

endmodule

// File: rtl/tx2b1q_sym_src.sv
// Module: tx2b1q_sym_src (top)
// Produces one registered 2B1Q symbol per sym_stb pulse according to the
// selected mode, with an optional pass through the scrambler.
// Assumes: sym_stb is a single-cycle pulse; inputs are sampled on it.
module tx2b1q_sym_src
    import tx2b1q_pkg::*;
#(
    parameter int SCR_LEN = 23,
    parameter int TAP_A   = 5,
    parameter int TAP_B   = 18,
    parameter int LVL_W   = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    sym_stb,
    input  logic [2:0]              mode_sel,
    input  logic                    poly_sel,
    input  logic                    cu_sign,
    input  logic                    cu_mag,
    output logic                    sym_sign,
    output logic                    sym_mag,
    output logic signed [LVL_W-1:0] sym_level
);

    localparam int BITS_PER_SYM = 2;

    sym_ctrl_t                 ctrl;
    logic [BITS_PER_SYM-1:0]   scr_din;
    logic [BITS_PER_SYM-1:0]   scr_dout;
    logic [SCR_LEN-1:0]        scr_state;
    logic                      scr_adv;

    tx2b1q_mode_dec u_dec (
        .mode_i (mode_sel),
        .ctrl_o (ctrl)
    );

    // Scrambler input: channel pair (sign first) or constant ones
    assign scr_din = ctrl.use_data ? {cu_mag, cu_sign} : '1;
    assign scr_adv = sym_stb && (ctrl.steps != 2'd0);

    tx2b1q_scr_core #(
        .LEN       (SCR_LEN),
        .TAP_A     (TAP_A),
        .TAP_B     (TAP_B),
        .MAX_STEPS (BITS_PER_SYM)
    ) u_scr (
        .clk        (clk),
        .rst_n      (rst_n),
        .adv_i      (scr_adv),
        .poly_sel_i (poly_sel),
        .steps_i    (ctrl.steps),
        .din_i      (scr_din),
        .dout_o     (scr_dout),
        .state_o    (scr_state)
    );

    // Symbol register, updated only on a strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sym_sign <= 1'b0;
            sym_mag  <= 1'b0;
        end else if (sym_stb) begin
            if (ctrl.idle) begin
                sym_sign <= 1'b0;
                sym_mag  <= 1'b0;
            end else if (ctrl.bypass) begin
                sym_sign <= cu_sign;
                sym_mag  <= 1'b0;
            end else begin
                sym_sign <= scr_dout[0];
                sym_mag  <= ctrl.two_lvl ? 1'b0 : scr_dout[1];
            end
        end
    end

    tx2b1q_lvl_map #(.LVL_W(LVL_W)) u_lvl (
        .sign_i  (sym_sign),
        .mag_i   (sym_mag),
        .level_o (sym_level)
    );

endmodule

// File: rtl/tx2b1q_sym_src_chk.sv
// Module: tx2b1q_sym_src_chk
// Assertion checker bound to tx2b1q_sym_src; relates ports and scrambler
// state across strobes. Assumes the default level width of 3 bits.
module tx2b1q_sym_src_chk #(
    parameter int LEN   = 23,
    parameter int LVL_W = 3
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    sym_stb,
    input logic [2:0]              mode_sel,
    input logic                    cu_sign,
    input logic                    sym_sign,
    input logic                    sym_mag,
    input logic signed [LVL_W-1:0] sym_level,
    input logic [LEN-1:0]          scr_state
);

    logic idle_mode;
    assign idle_mode = (mode_sel == 3'b000) || (mode_sel == 3'b001) ||
                       (mode_sel == 3'b010) || (mode_sel == 3'b100);

    p_reset_state_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (!sym_sign && !sym_mag && (&scr_state)));

    p_hold_out_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sym_stb)) |-> ($stable(sym_sign) && $stable(sym_mag)));

    p_hold_scr_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && !$past(sym_stb)) |-> $stable(scr_state));

    p_bypass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sym_stb) && ($past(mode_sel) == 3'b110))
        |-> ((sym_sign == $past(cu_sign)) && !sym_mag && $stable(scr_state)));

    p_two_lvl_mag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sym_stb) && ($past(mode_sel) == 3'b111)) |-> !sym_mag);

    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(rst_n) && $past(sym_stb) && $past(idle_mode))
        |-> (!sym_sign && !sym_mag && $stable(scr_state)));

    p_level_pos_r9: assert property (@(posedge clk) disable iff (!rst_n)
        sym_sign |-> (sym_level == (sym_mag ? LVL_W'(1) : LVL_W'(3))));

    p_level_neg_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !sym_sign |-> (sym_level == (sym_mag ? -LVL_W'(1) : -LVL_W'(3))));

endmodule

bind tx2b1q_sym_src tx2b1q_sym_src_chk #(.LEN(SCR_LEN), .LVL_W(LVL_W)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sym_stb   (sym_stb),
    .mode_sel  (mode_sel),
    .cu_sign   (cu_sign),
    .sym_sign  (sym_sign),
    .sym_mag   (sym_mag),
    .sym_level (sym_level),
    .scr_state (scr_state)
);

// File: tb/tx2b1q_sym_src_tb_top.sv
`timescale 1ns/1ps
// Directed bench for tx2b1q_sym_src; one task per scenario.
module tx2b1q_sym_src_tb_top;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              sym_stb = 1'b0;
    logic [2:0]        mode_sel = 3'b000;
    logic              poly_sel = 1'b0;
    logic              cu_sign = 1'b0;
    logic              cu_mag = 1'b0;
    logic              sym_sign;
    logic              sym_mag;
    logic signed [2:0] sym_level;

    int          n_checks = 0;
    int          n_errors = 0;
    logic [22:0] ref_s;
    logic [31:0] prng = 32'h1234_5678;

    always #4 clk = ~clk;

    tx2b1q_sym_src dut_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .sym_stb   (sym_stb),
        .mode_sel  (mode_sel),
        .poly_sel  (poly_sel),
        .cu_sign   (cu_sign),
        .cu_mag    (cu_mag),
        .sym_sign  (sym_sign),
        .sym_mag   (sym_mag),
        .sym_level (sym_level)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int exp_level(input logic s, input logic m);
        if (s) return m ? 1 : 3;
        return m ? -1 : -3;
    endfunction

    // Reference scrambler step, newest bit at index 0
    task automatic ref_step(input logic d, input logic p, output logic b);
        b = d ^ (p ? ref_s[17] : ref_s[4]) ^ ref_s[22];
        ref_s = {ref_s[21:0], b};
    endtask

    function automatic logic [31:0] next_rand(input logic [31:0] x);
        logic [31:0] y;
        y = x ^ (x << 13);
        y = y ^ (y >> 17);
        y = y ^ (y << 5);
        return y;
    endfunction

    // Apply one strobe and wait until the registered result is visible
    task automatic send(input logic [2:0] md, input logic p, input logic s, input logic m);
        @(negedge clk);
        mode_sel = md; poly_sel = p; cu_sign = s; cu_mag = m; sym_stb = 1'b1;
        @(negedge clk);
        sym_stb = 1'b0;
    endtask

    // Send one symbol and compare against the reference model
    task automatic run_sym(input string tag, input logic [2:0] md, input logic p,
                           input logic s, input logic m);
        logic es, em;
        es = 1'b0; em = 1'b0;
        case (md)
            3'b011: begin ref_step(1'b1, p, es); ref_step(1'b1, p, em); end
            3'b101: begin ref_step(s, p, es);    ref_step(m, p, em);    end
            3'b110: begin es = s; em = 1'b0; end
            3'b111: begin ref_step(1'b1, p, es); em = 1'b0; end
            default: begin es = 1'b0; em = 1'b0; end
        endcase
        send(md, p, s, m);
        check({tag, " sign"}, int'(sym_sign), int'(es));
        check({tag, " mag"}, int'(sym_mag), int'(em));
        check({tag, " level R9"}, int'(sym_level), exp_level(es, em));
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 reset sign", int'(sym_sign), 0);
        check("R1 reset mag", int'(sym_mag), 0);
        check("R1 reset level", int'(sym_level), -3);
        rst_n = 1'b1;
        ref_s = '1;
        send(3'b011, 1'b0, 1'b0, 1'b0);
        check("R1 first ones symbol level", int'(sym_level), 1);
        ref_s = {ref_s[20:0], 2'b11};
    endtask

    task automatic t_ones4();
        for (int i = 0; i < 20; i++) run_sym("R3 R8 ones4 p0", 3'b011, 1'b0, 1'b0, 1'b0);
        for (int i = 0; i < 20; i++) run_sym("R3 R8 ones4 p1", 3'b011, 1'b1, 1'b1, 1'b0);
    endtask

    task automatic t_data4();
        for (int i = 0; i < 40; i++) begin
            prng = next_rand(prng);
            run_sym("R4 R8 data4", 3'b101, prng[5], prng[0], prng[1]);
        end
    endtask

    task automatic t_unscr2();
        for (int i = 0; i < 8; i++) run_sym("R5 unscr2", 3'b110, 1'(i % 3 == 0), 1'(i % 2), 1'b1);
        run_sym("R5 scrambler untouched", 3'b011, 1'b0, 1'b0, 1'b0);
    endtask

    task automatic t_ones2();
        for (int i = 0; i < 16; i++) run_sym("R6 ones2", 3'b111, 1'(i >= 8), 1'b1, 1'b1);
    endtask

    task automatic t_idle();
        run_sym("R7 idle 000", 3'b000, 1'b1, 1'b1, 1'b1);
        run_sym("R7 idle 001", 3'b001, 1'b0, 1'b1, 1'b0);
        run_sym("R7 idle 010", 3'b010, 1'b1, 1'b0, 1'b1);
        run_sym("R7 idle 100", 3'b100, 1'b0, 1'b1, 1'b1);
        for (int i = 0; i < 3; i++) run_sym("R7 scrambler untouched", 3'b101, 1'b0, 1'b1, 1'b0);
    endtask

    task automatic t_hold();
        logic hs, hm;
        run_sym("R2 pre-hold", 3'b101, 1'b1, 1'b0, 1'b1);
        hs = sym_sign; hm = sym_mag;
        for (int i = 0; i < 6; i++) begin
            @(negedge clk);
            mode_sel = 3'(i + 2); poly_sel = ~poly_sel; cu_sign = ~cu_sign; cu_mag = ~cu_mag;
            @(negedge clk);
            check("R2 hold sign", int'(sym_sign), int'(hs));
            check("R2 hold mag", int'(sym_mag), int'(hm));
        end
        for (int i = 0; i < 3; i++) run_sym("R2 no step without strobe", 3'b011, 1'b1, 1'b0, 1'b0);
    endtask

    // Descramble the output stream from an all-zero state
    task automatic t_selfsync();
        logic [22:0] ds;
        logic        sent [0:1];
        logic        rec;
        int          nbits;
        ds = '0; nbits = 0;
        for (int i = 0; i < 30; i++) begin
            prng = next_rand(prng);
            sent[0] = prng[2]; sent[1] = prng[7];
            run_sym("R10 feed", 3'b101, 1'b1, sent[0], sent[1]);
            for (int j = 0; j < 2; j++) begin
                logic rb;
                rb = (j == 0) ? sym_sign : sym_mag;
                rec = rb ^ ds[17] ^ ds[22];
                ds = {ds[21:0], rb};
                nbits++;
                if (nbits > 23) check("R10 recovered bit", int'(rec), int'(sent[j]));
            end
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        ref_s = '1;
        t_reset();
        t_ones4();
        t_data4();
        t_unscr2();
        t_ones2();
        t_idle();
        t_hold();
        t_selfsync();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

endmodule